// File: doc/BRIEF.md
# Page-Buffered Write Cycle Controller

This block sits behind a serial memory front end. It collects the data bytes of one write transaction into a 16-byte page latch. It then commits those bytes to a 256-byte memory array in a single programming cycle, and the cycle only begins when the STOP that closes the transaction arrives. The front end gives the block four things:

- a start pulse that carries the byte address;
- a strobe for each data byte;
- a STOP strobe;
- the level of a write-protect pin.

For every byte strobe the block returns an accept or refuse verdict.

During a programming cycle the block raises `busy`, and the front end then acknowledges nothing. The cycle first drains every received slot of the latch into the array, one slot per clock. It then holds `busy` for a further count of clocks set by `prog_cycles`. At every STOP the block reports the final pointer, so that a shared address counter can serve a following current-address read.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, `busy`, `ack_valid`, `ack_ok`, `arr_we` and `ptr_valid` are all 0.
- R2: A byte strobe inside an open transaction, with `busy` low, `wp` low and no refusal so far, gives `ack_valid`=1 and `ack_ok`=1 in the cycle after the strobe.
- R3: Each accepted byte lands at array address {start[7:4], slot}. The slot starts at start[3:0] and increases by one modulo 16 after each accepted byte, while bits 7:4 never change. When more than 16 bytes arrive, later bytes overwrite the slot they wrap onto.
- R4: Nothing is written to the array before STOP. On a STOP that ends a transaction with at least one accepted byte, `busy` is 1 in the following cycle. Each received slot is then written exactly once, which makes min(n,16) writes for n accepted bytes, and no other address is written.
- R5: `busy` stays high for exactly 16 + max(1, P) cycles, where P is the value of `prog_cycles` at STOP. Every array write happens while `busy` is high.
- R6: While `busy` is high, every byte strobe is answered with `ack_valid`=1 and `ack_ok`=0, and a start pulse has no effect.
- R7: A data byte that arrives while `wp` is 1 is answered with `ack_ok`=0 and marks the transaction refused. All later bytes of that transaction are also refused, the pointer does not advance, and the closing STOP starts no programming cycle and writes nothing.
- R8: A STOP after a start with no data bytes (a dummy write) raises no `busy` and writes nothing.
- R9: One cycle after any STOP that closes a transaction, `ptr_valid` pulses for one cycle. `ptr_out` then equals {start[7:4], (start[3:0] + accepted count) mod 16}.
- R10: A byte strobe when no transaction is open (no start since the last STOP or programming cycle) gets `ack_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Opens a write transaction (one-cycle pulse) |
| wr_addr | input | 8 | Byte address carried by the start pulse |
| byte_stb | input | 1 | One-cycle strobe for a received data byte |
| byte_data | input | 8 | Data byte qualified by `byte_stb` |
| stop_stb | input | 1 | One-cycle STOP strobe |
| wp | input | 1 | Write-protect pin level |
| prog_cycles | input | 16 | Extra busy cycles after the drain, sampled at STOP |
| busy | output | 1 | Programming cycle in progress |
| ack_valid | output | 1 | Verdict for the previous cycle's byte strobe is present |
| ack_ok | output | 1 | 1 = byte accepted, 0 = refused |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 8 | Array write address |
| arr_data | output | 8 | Array write data |
| ptr_valid | output | 1 | One-cycle pulse after STOP |
| ptr_out | output | 8 | Final pointer reported at STOP |

## Verification
The main sweep runs transactions of 1 to 20 bytes from start addresses spread over the array and with several `prog_cycles` values, zero among them. Lengths up to 16 confirm the slot stepping and the write count. Longer lengths expose the wrap overwrite, and starts near a slot value of 15 show that the high nibble never carries. A shadow copy of the array, computed from the requirements, is compared in full after every cycle of programming. Separate patterns cover the dummy write, the write-protected transaction, stray bytes with no open transaction, and bytes and starts arriving while `busy` is high; each shows a different way a byte must leave the array untouched.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_DRAIN   = 2'd2,
    ST_HOLD    = 2'd3
  } pwc_state_e;
endpackage

// File: rtl/pwc_page_latch.sv
// Page latch: one write port, registered read port (block-RAM friendly).
module pwc_page_latch #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pwc_tracker.sv
// Page pointer and per-slot received mask. Only the low IDX_W bits advance.
module pwc_tracker #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [ADDR_W-1:0]      load_addr,
  input  logic                   advance,
  output logic [ADDR_W-1:0]      ptr,
  output logic [(1<<IDX_W)-1:0]  mask
);
  localparam int SLOTS = 1 << IDX_W;

  logic [IDX_W-1:0]        lo_q;
  logic [ADDR_W-IDX_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load) begin
      lo_q <= load_addr[IDX_W-1:0];
      hi_q <= load_addr[ADDR_W-1:IDX_W];
    end else if (advance) begin
      lo_q <= lo_q + 1'b1;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst || load)
        mask[s] <= 1'b0;
      else if (advance && (lo_q == IDX_W'(s)))
        mask[s] <= 1'b1;
    end
  end

  assign ptr = {hi_q, lo_q};
endmodule

// File: rtl/pwc_timer.sv
// Hold timer: limit latched on load; expire when count+1 reaches limit (min 1 cycle).
module pwc_timer #(
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CYC_W-1:0] limit,
  input  logic             run,
  output logic             expire
);
  logic [CYC_W-1:0] limit_q;
  logic [CYC_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      limit_q <= limit;
      cnt_q   <= '0;
    end else if (run && !expire) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_q};
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4,
  parameter int CYC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_stb,
  input  logic              wp,
  input  logic [CYC_W-1:0]  prog_cycles,
  output logic              busy,
  output logic              ack_valid,
  output logic              ack_ok,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              ptr_valid,
  output logic [ADDR_W-1:0] ptr_out
);
  import pwc_pkg::*;

  localparam int SLOTS = 1 << IDX_W;

  pwc_state_e state_q, state_d;

  logic [ADDR_W-1:0] ptr;
  logic [SLOTS-1:0]  mask;
  logic              refused_q;
  logic [IDX_W-1:0]  drain_idx_q;
  logic              expire;
  logic              open_txn;
  logic              start_ok;
  logic              accept;
  logic              stop_ok;
  logic              commit;

  assign open_txn = (state_q == ST_COLLECT);
  assign start_ok = wr_start && ((state_q == ST_IDLE) || open_txn);
  assign accept   = byte_stb && open_txn && !start_ok && !wp && !refused_q;
  assign stop_ok  = stop_stb && open_txn && !start_ok;
  assign commit   = stop_ok && (|mask) && !refused_q;

  pwc_tracker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .load      (start_ok),
    .load_addr (wr_addr),
    .advance   (accept),
    .ptr       (ptr),
    .mask      (mask)
  );

  pwc_page_latch #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_latch (
    .clk   (clk),
    .we    (accept),
    .waddr (ptr[IDX_W-1:0]),
    .wdata (byte_data),
    .raddr (drain_idx_q),
    .rdata (arr_data)
  );

  pwc_timer #(.CYC_W(CYC_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (commit),
    .limit  (prog_cycles),
    .run    (state_q == ST_HOLD),
    .expire (expire)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (start_ok) state_d = ST_COLLECT;
      ST_COLLECT: begin
        if (start_ok)    state_d = ST_COLLECT;
        else if (commit) state_d = ST_DRAIN;
        else if (stop_ok) state_d = ST_IDLE;
      end
      ST_DRAIN:   if (drain_idx_q == IDX_W'(SLOTS - 1)) state_d = ST_HOLD;
      ST_HOLD:    if (expire) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      busy        <= 1'b0;
      refused_q   <= 1'b0;
      drain_idx_q <= '0;
      ack_valid   <= 1'b0;
      ack_ok      <= 1'b0;
      arr_we      <= 1'b0;
      arr_addr    <= '0;
      ptr_valid   <= 1'b0;
      ptr_out     <= '0;
    end else begin
      state_q   <= state_d;
      busy      <= (state_d == ST_DRAIN) || (state_d == ST_HOLD);
      ack_valid <= byte_stb;
      ack_ok    <= accept;
      ptr_valid <= stop_ok;
      if (stop_ok) ptr_out <= ptr;

      if (start_ok)
        refused_q <= 1'b0;
      else if (byte_stb && open_txn && wp)
        refused_q <= 1'b1;

      if (state_q == ST_DRAIN) begin
        arr_we      <= mask[drain_idx_q];
        arr_addr    <= {ptr[ADDR_W-1:IDX_W], drain_idx_q};
        drain_idx_q <= drain_idx_q + 1'b1;
      end else begin
        arr_we      <= 1'b0;
        drain_idx_q <= '0;
      end
    end
  end
endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_start,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              byte_stb,
  input logic              stop_stb,
  input logic              wp,
  input logic              busy,
  input logic              ack_valid,
  input logic              ack_ok,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              ptr_valid,
  input logic [ADDR_W-1:0] ptr_out
);
  logic [ADDR_W-IDX_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) hi_q <= '0;
    else if (wr_start && !busy) hi_q <= wr_addr[ADDR_W-1:IDX_W];
  end

  // R1
  always_ff @(posedge clk) begin
    if ($past(rst)) begin
      p_reset_quiet_r1: assert (!busy && !ack_valid && !arr_we && !ptr_valid);
    end
  end

  p_ack_follows_r2: assert property (@(posedge clk) disable iff (rst)
    byte_stb |=> ack_valid);

  p_page_hi_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> (arr_addr[ADDR_W-1:IDX_W] == hi_q));

  p_busy_from_stop_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_stb));

  p_write_in_busy_r5: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);

  p_nack_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && byte_stb) |=> !ack_ok);

  p_wp_refuses_r7: assert property (@(posedge clk) disable iff (rst)
    (wp && byte_stb) |=> !ack_ok);

  p_ptr_hi_fixed_r9: assert property (@(posedge clk) disable iff (rst)
    ptr_valid |-> (ptr_out[ADDR_W-1:IDX_W] == hi_q));

  p_ok_needs_valid_r2: assert property (@(posedge clk) disable iff (rst)
    ack_ok |-> ack_valid);
endmodule

bind page_write_ctrl pwc_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_start  (wr_start),
  .wr_addr   (wr_addr),
  .byte_stb  (byte_stb),
  .stop_stb  (stop_stb),
  .wp        (wp),
  .busy      (busy),
  .ack_valid (ack_valid),
  .ack_ok    (ack_ok),
  .arr_we    (arr_we),
  .arr_addr  (arr_addr),
  .ptr_valid (ptr_valid),
  .ptr_out   (ptr_out)
);

// File: tb/page_write_ctrl_tb.sv
`timescale 1ns/1ps
module page_write_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_start = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic        byte_stb = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        stop_stb = 1'b0;
  logic        wp = 1'b0;
  logic [15:0] prog_cycles = 16'd2;
  logic        busy, ack_valid, ack_ok, arr_we, ptr_valid;
  logic [7:0]  arr_addr, arr_data, ptr_out;

  always #4 clk = ~clk;

  page_write_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_start(wr_start), .wr_addr(wr_addr),
    .byte_stb(byte_stb), .byte_data(byte_data), .stop_stb(stop_stb),
    .wp(wp), .prog_cycles(prog_cycles), .busy(busy), .ack_valid(ack_valid),
    .ack_ok(ack_ok), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_data(arr_data), .ptr_valid(ptr_valid), .ptr_out(ptr_out)
  );

  int total = 0;
  int bad = 0;
  int write_cnt = 0;
  int busy_cnt = 0;
  logic [7:0] exp_mem [256];
  logic [7:0] got_mem [256];

  always @(negedge clk) begin
    if (arr_we) begin
      got_mem[arr_addr] <= arr_data;
      write_cnt <= write_cnt + 1;
    end
    if (busy) busy_cnt <= busy_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [7:0] a);
    @(negedge clk); wr_start = 1'b1; wr_addr = a;
    @(negedge clk); wr_start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit exp_ok, input string req);
    @(negedge clk); byte_stb = 1'b1; byte_data = d;
    @(negedge clk); byte_stb = 1'b0;
    check(ack_valid && (ack_ok == exp_ok), req, {ack_valid, ack_ok}, {1'b1, exp_ok});
  endtask

  task automatic do_stop(input logic [7:0] exp_ptr, input bit exp_busy);
    @(negedge clk); stop_stb = 1'b1;
    @(negedge clk); stop_stb = 1'b0;
    check(ptr_valid && ptr_out == exp_ptr, "R9 ptr", ptr_out, exp_ptr);
    check(busy == exp_busy, "R4/R8 busy after stop", busy, exp_busy);
    @(negedge clk);
    check(!ptr_valid, "R9 ptr pulse width", ptr_valid, 0);
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 5000 && busy; g++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic compare_mem(input string req);
    int mism = 0;
    for (int i = 0; i < 256; i++) if (got_mem[i] !== exp_mem[i]) mism++;
    check(mism == 0, req, mism, 0);
  endtask

  task automatic run_page(input logic [7:0] base, input int n, input int p);
    int wc0, bz;
    logic [3:0] lo;
    prog_cycles = 16'(p);
    do_start(base);
    for (int j = 0; j < n; j++) begin
      logic [7:0] d;
      d = 8'((base * 7) + (j * 13) + n + 1);
      send_byte(d, 1'b1, "R2 accept");
      lo = 4'(base[3:0] + j);
      exp_mem[{base[7:4], lo}] = d;
    end
    @(negedge clk);
    wc0 = write_cnt;
    check(wc0 == write_cnt && !busy, "R4 nothing before stop", busy, 0);
    busy_cnt = 0;
    do_stop({base[7:4], 4'(base[3:0] + n)}, 1'b1);
    wait_idle();
    bz = (p < 1) ? 17 : 16 + p;
    check(busy_cnt == bz, "R5 busy length", busy_cnt, bz);
    check(write_cnt - wc0 == ((n > 16) ? 16 : n), "R4 write count",
          write_cnt - wc0, (n > 16) ? 16 : n);
    compare_mem("R3 array contents");
  endtask

  initial begin
    for (int w = 0; w < 100000; w++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int wc0;
    for (int i = 0; i < 256; i++) begin exp_mem[i] = '0; got_mem[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(!busy && !ack_valid && !ack_ok && !arr_we && !ptr_valid, "R1 reset",
          {busy, ack_valid, ack_ok, arr_we, ptr_valid}, 0);

    // R10: stray byte with no open transaction
    send_byte(8'hA5, 1'b0, "R10 stray byte");

    // R3 R4 R5: sweep of lengths, bases and hold counts
    for (int n = 1; n <= 20; n++) run_page(8'((n * 53) + 5), n, n % 4);
    run_page(8'h2F, 3, 6);

    // R8: dummy write
    wc0 = write_cnt;
    do_start(8'h9C);
    do_stop(8'h9C, 1'b0);
    check(write_cnt == wc0, "R8 dummy write no array write", write_cnt, wc0);

    // R7: write protect
    wc0 = write_cnt;
    do_start(8'h47);
    wp = 1'b1;
    send_byte(8'h11, 1'b0, "R7 wp first byte");
    wp = 1'b0;
    send_byte(8'h22, 1'b0, "R7 later byte refused");
    do_stop(8'h47, 1'b0);
    repeat (20) @(negedge clk);
    check(write_cnt == wc0, "R7 no programming", write_cnt, wc0);
    compare_mem("R7 array untouched");

    // R6: activity during busy
    prog_cycles = 16'd10;
    do_start(8'h60);
    send_byte(8'h5A, 1'b1, "R2 accept");
    exp_mem[8'h60] = 8'h5A;
    do_stop(8'h61, 1'b1);
    send_byte(8'hEE, 1'b0, "R6 byte during busy");
    do_start(8'hF0);
    send_byte(8'hDD, 1'b0, "R6 byte after ignored start");
    wait_idle();
    compare_mem("R6 array after busy activity");
    send_byte(8'hCC, 1'b0, "R6 R10 start during busy ignored");
    compare_mem("R10 array unchanged");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule